// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is the processor side of an 8-bit external bus. It runs read and write cycles over a 16-bit address. The upper address byte has pins of its own. The lower address byte and the data byte take turns on one shared bidirectional byte.

Each cycle has four phases, each lasting `PH_CYC` clocks:
- The address strobe goes high and the low address is placed on the shared pins.
- The strobe falls while that address is still driven, so an external transparent latch captures it.
- The E phase goes high and data moves.
- E goes low so the bus can turn around.

The read/write line gives the direction for the whole cycle. Read data is sampled in the last clock of the E-high phase.

Requests arrive on a valid/ready interface.
- A requester raises `req_valid` and holds the address, write data and write flag steady until the clock edge where `req_ready` is also high. The request is taken at that edge.
- `req_ready` is back-pressure. It is low while a cycle is in flight, except in the final turnaround clock. That exception lets a waiting request start the next cycle with no idle gap.
- The response has no back-pressure. `rsp_done` pulses for one clock and `rsp_rdata` holds the last captured read byte.

When `mode_exp` is low, the block works in single-chip mode and the bus pins become parallel ports with handshake strobes:
- The upper byte is an output port.
- The shared byte is a port whose direction is set per bit.
- The strobe input is an edge-sensitive input that sets a sticky flag.
- The read/write pin carries a one-clock output strobe after each write to the output port.

`mode_exp` may change only while no cycle is in flight.

Top module: `mxbus_ctrl`

## Requirements
- R1: `req_ready` is high only in expanded mode, and only when the bus is idle or in the final clock of the turnaround phase. A request is taken at a clock edge where `req_valid` and `req_ready` are both high. With `req_valid` low, no cycle starts and the address strobe stays low.
- R2: During the E-high phase of a cycle, the upper pins `pin_hi_out` carry bits 15..8 of the accepted address.
- R3: The address strobe `pin_as_o` is high for the first `PH_CYC` clocks of a cycle, with bits 7..0 of the address driven on the shared pins (`pin_ad_oe` all ones). The same value stays driven through the strobe's falling edge and the following phase. The strobe and E are never high together.
- R4: On a read, the shared pins are released (`pin_ad_oe` all zeros) while E is high. `rsp_rdata` receives the value on `pin_ad_i` in the last clock of E high.
- R5: On a write, the write data is driven on all shared pins throughout the E-high phase. The pins are released when E falls.
- R6: `pin_rw_o` is 1 for a read and 0 for a write for the whole cycle, and 1 while idle.
- R7: `rsp_done` is a one-clock pulse in the clock after the turnaround phase ends. Requests offered back to back complete every 4·`PH_CYC` clocks.
- R8: In single-chip mode:
  - `req_ready`, `pin_e` and `pin_as_oe` are 0.
  - `pin_hi_out` shows the output-port register.
  - `pin_ad_o` shows the shared-port register, and `pin_ad_oe` equals `port_lo_dir` (1 = drive).
  - `port_lo_in` shows `pin_ad_i` one clock later.
- R9: In single-chip mode, `port_hi_wr` loads `port_hi_data` into the output port. In the next clock `pin_rw_o` is high for exactly one clock as the output strobe.
- R10: In single-chip mode, a rising edge on `pin_as_i` sets `stra_flag` at the third clock edge after the edge. The flag stays set until `stra_clr` is pulsed, even while the input stays high. A new rising edge is needed to set it again.
- R11: In expanded mode, port writes and edges on `pin_as_i` have no effect. No output strobe appears, and the port registers and `stra_flag` keep their values when the block returns to single-chip mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_exp | input | 1 | 1 = expanded bus, 0 = single-chip ports |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this clock |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_done | output | 1 | One-clock pulse at the end of a cycle |
| rsp_rdata | output | DW | Last captured read data |
| port_hi_wr | input | 1 | Write strobe for the output port |
| port_hi_data | input | AW-DW | Output-port write value |
| port_lo_wr | input | 1 | Write strobe for the shared-byte port |
| port_lo_data | input | DW | Shared-byte port write value |
| port_lo_dir | input | DW | Per-bit drive enable for the shared-byte port |
| port_lo_in | output | DW | Registered shared-pin input value |
| stra_clr | input | 1 | Clears the input-strobe flag |
| stra_flag | output | 1 | Sticky input-strobe flag |
| pin_hi_out | output | AW-DW | Upper address byte or output port |
| pin_ad_o | output | DW | Shared pins, output value |
| pin_ad_oe | output | DW | Shared pins, per-bit output enable |
| pin_ad_i | input | DW | Shared pins, input value |
| pin_as_o | output | 1 | Address strobe output |
| pin_as_oe | output | 1 | Address-strobe pin output enable |
| pin_as_i | input | 1 | Strobe pin input (single-chip input strobe) |
| pin_rw_o | output | 1 | Read/write line, or output strobe in single-chip mode |
| pin_e | output | 1 | E phase, high while data moves |

## Verification
The bench builds the block with `PH_CYC` = 2 and the default 16-bit address and 8-bit data widths. With each phase two clocks long, a model of the external transparent latch can show that the low address holds across a multi-clock strobe-low phase. The same setting exposes whether read data is taken in the last clock of E high rather than the first. It also makes the back-to-back completion spacing of eight clocks distinguishable from a design that inserts an idle clock between cycles.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;

  // Phase of an external bus cycle
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ASH  = 3'd1,   // strobe high, low address driven
    PH_ASL  = 3'd2,   // strobe low, low address still driven
    PH_EHI  = 3'd3,   // E high, data transfer
    PH_ELO  = 3'd4    // E low, turnaround
  } bus_ph_e;

endpackage

// File: rtl/mxbus_seq.sv
module mxbus_seq
  import mxbus_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int PH_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_write,
  input  logic [DW-1:0] bus_in,
  output bus_ph_e       phase,
  output logic [AW-1:0] cur_addr,
  output logic [DW-1:0] cur_wdata,
  output logic          cur_write,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata
);

  localparam int CW = (PH_CYC > 1) ? $clog2(PH_CYC) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(PH_CYC - 1);

  logic [CW-1:0] cnt;
  logic          ph_last;
  logic          accept;

  assign ph_last   = (cnt == LAST_CNT);
  assign req_ready = en && ((phase == PH_IDLE) || ((phase == PH_ELO) && ph_last));
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_write <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= (phase == PH_ELO) && ph_last;
      if ((phase == PH_EHI) && ph_last && !cur_write) begin
        rsp_rdata <= bus_in;
      end
      if (accept) begin
        phase     <= PH_ASH;
        cnt       <= '0;
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
        cur_write <= req_write;
      end else if (phase != PH_IDLE) begin
        if (ph_last) begin
          cnt <= '0;
          unique case (phase)
            PH_ASH:  phase <= PH_ASL;
            PH_ASL:  phase <= PH_EHI;
            PH_EHI:  phase <= PH_ELO;
            default: phase <= PH_IDLE;
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (phase == PH_ASH)) else $error("accept"); // R1

  AST_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase inside {PH_ASL, PH_EHI, PH_ELO}) |-> ($stable(cur_write) && $stable(cur_addr)))
    else $error("hold"); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done) else $error("done"); // R7

endmodule

// File: rtl/mxbus_port.sv
module mxbus_port #(
  parameter int DW = 8,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          hi_wr,
  input  logic [HW-1:0] hi_data,
  input  logic          lo_wr,
  input  logic [DW-1:0] lo_data,
  input  logic [DW-1:0] lo_pins,
  input  logic          stra_in,
  input  logic          stra_clr,
  output logic [HW-1:0] hi_q,
  output logic [DW-1:0] lo_q,
  output logic [DW-1:0] lo_sampled,
  output logic          strb,
  output logic          stra_flag
);

  logic [2:0] stra_sync;
  logic       stra_rise;

  assign stra_rise = stra_sync[1] && !stra_sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stra_sync  <= '0;
      lo_sampled <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      strb       <= 1'b0;
      stra_flag  <= 1'b0;
    end else begin
      stra_sync  <= {stra_sync[1:0], stra_in};
      lo_sampled <= lo_pins;
      strb       <= en && hi_wr;
      if (en && hi_wr) hi_q <= hi_data;
      if (en && lo_wr) lo_q <= lo_data;
      if (en && stra_rise)  stra_flag <= 1'b1;
      else if (stra_clr)    stra_flag <= 1'b0;
    end
  end

  AST_STRB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> $past(en && hi_wr)) else $error("strb"); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stra_flag && !stra_clr) |=> stra_flag) else $error("flag"); // R10

  AST_PORT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(hi_q) && $stable(lo_q))) else $error("ignore"); // R11

endmodule

// File: rtl/mxbus_pinmux.sv
module mxbus_pinmux
  import mxbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             mode_exp,
  input  bus_ph_e          phase,
  input  logic [AW-1:0]    cur_addr,
  input  logic [DW-1:0]    cur_wdata,
  input  logic             cur_write,
  input  logic [AW-DW-1:0] hi_q,
  input  logic [DW-1:0]    lo_q,
  input  logic [DW-1:0]    lo_dir,
  input  logic             strb,
  output logic [AW-DW-1:0] pin_hi_out,
  output logic [DW-1:0]    pin_ad_o,
  output logic [DW-1:0]    pin_ad_oe,
  output logic             pin_as_o,
  output logic             pin_as_oe,
  output logic             pin_rw_o,
  output logic             pin_e
);

  always_comb begin
    if (mode_exp) begin
      pin_hi_out = cur_addr[AW-1:DW];
      pin_as_o   = (phase == PH_ASH);
      pin_as_oe  = 1'b1;
      pin_e      = (phase == PH_EHI);
      pin_rw_o   = (phase == PH_IDLE) ? 1'b1 : !cur_write;
      unique case (phase)
        PH_ASH, PH_ASL: begin
          pin_ad_o  = cur_addr[DW-1:0];
          pin_ad_oe = '1;
        end
        PH_EHI: begin
          pin_ad_o  = cur_write ? cur_wdata : '0;
          pin_ad_oe = cur_write ? '1 : '0;
        end
        default: begin
          pin_ad_o  = '0;
          pin_ad_oe = '0;
        end
      endcase
    end else begin
      pin_hi_out = hi_q;
      pin_ad_o   = lo_q;
      pin_ad_oe  = lo_dir;
      pin_as_o   = 1'b0;
      pin_as_oe  = 1'b0;
      pin_e      = 1'b0;
      pin_rw_o   = strb;
    end
  end

endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
  import mxbus_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int PH_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_exp,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_write,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_rdata,
  input  logic             port_hi_wr,
  input  logic [AW-DW-1:0] port_hi_data,
  input  logic             port_lo_wr,
  input  logic [DW-1:0]    port_lo_data,
  input  logic [DW-1:0]    port_lo_dir,
  output logic [DW-1:0]    port_lo_in,
  input  logic             stra_clr,
  output logic             stra_flag,
  output logic [AW-DW-1:0] pin_hi_out,
  output logic [DW-1:0]    pin_ad_o,
  output logic [DW-1:0]    pin_ad_oe,
  input  logic [DW-1:0]    pin_ad_i,
  output logic             pin_as_o,
  output logic             pin_as_oe,
  input  logic             pin_as_i,
  output logic             pin_rw_o,
  output logic             pin_e
);

  localparam int HW = AW - DW;

  bus_ph_e       phase;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  logic          cur_write;
  logic [HW-1:0] hi_q;
  logic [DW-1:0] lo_q;
  logic          strb;

  mxbus_seq #(.AW(AW), .DW(DW), .PH_CYC(PH_CYC)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (mode_exp),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_write (req_write),
    .bus_in    (pin_ad_i),
    .phase     (phase),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .cur_write (cur_write),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );

  mxbus_port #(.DW(DW), .HW(HW)) i_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (!mode_exp),
    .hi_wr      (port_hi_wr),
    .hi_data    (port_hi_data),
    .lo_wr      (port_lo_wr),
    .lo_data    (port_lo_data),
    .lo_pins    (pin_ad_i),
    .stra_in    (pin_as_i),
    .stra_clr   (stra_clr),
    .hi_q       (hi_q),
    .lo_q       (lo_q),
    .lo_sampled (port_lo_in),
    .strb       (strb),
    .stra_flag  (stra_flag)
  );

  mxbus_pinmux #(.AW(AW), .DW(DW)) i_pinmux (
    .mode_exp   (mode_exp),
    .phase      (phase),
    .cur_addr   (cur_addr),
    .cur_wdata  (cur_wdata),
    .cur_write  (cur_write),
    .hi_q       (hi_q),
    .lo_q       (lo_q),
    .lo_dir     (port_lo_dir),
    .strb       (strb),
    .pin_hi_out (pin_hi_out),
    .pin_ad_o   (pin_ad_o),
    .pin_ad_oe  (pin_ad_oe),
    .pin_as_o   (pin_as_o),
    .pin_as_oe  (pin_as_oe),
    .pin_rw_o   (pin_rw_o),
    .pin_e      (pin_e)
  );

  AST_AS_E_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_as_o && pin_e)) else $error("as/e"); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_exp && $fell(pin_as_o)) |-> ($stable(pin_ad_o) && (&pin_ad_oe)))
    else $error("addr hold"); // R3

  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_e && pin_rw_o) |-> (pin_ad_oe == '0)) else $error("release"); // R4

endmodule

// File: tb/test_mxbus_ctrl.sv
`timescale 1ns/1ps
module test_mxbus_ctrl;

  localparam int PH = 2;
  localparam int NV = 8;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  exp;
  } vec_t;

  // Untouched memory bytes read back as (low address) ^ 8'h5A
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h12A5, 8'h3C, 8'h00},
    '{1'b0, 16'h12A5, 8'h00, 8'h3C},
    '{1'b0, 16'h8001, 8'h00, 8'h5B},
    '{1'b1, 16'hFF00, 8'hFF, 8'h00},
    '{1'b1, 16'h00FF, 8'h00, 8'h00},
    '{1'b0, 16'hFF00, 8'h00, 8'hFF},
    '{1'b0, 16'h00FF, 8'h00, 8'h00},
    '{1'b0, 16'h7E42, 8'h00, 8'h18}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_exp = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_write = 1'b0;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic        port_hi_wr = 1'b0;
  logic [7:0]  port_hi_data = '0;
  logic        port_lo_wr = 1'b0;
  logic [7:0]  port_lo_data = '0;
  logic [7:0]  port_lo_dir = '0;
  logic [7:0]  port_lo_in;
  logic        stra_clr = 1'b0;
  logic        stra_flag;
  logic [7:0]  pin_hi_out;
  logic [7:0]  pin_ad_o;
  logic [7:0]  pin_ad_oe;
  logic [7:0]  pin_ad_i;
  logic        pin_as_o;
  logic        pin_as_oe;
  logic        pin_as_i = 1'b0;
  logic        pin_rw_o;
  logic        pin_e;

  logic [7:0]  ext_port = '0;
  logic [7:0]  lat_lo;
  logic [7:0]  mem [256];
  int          n_chk = 0;
  int          n_fail = 0;
  int          cyc = 0;
  int          k = 0;
  int          last_done = 0;
  logic        run_mon = 1'b0;
  logic        prev_as = 1'b0;
  logic        prev_e = 1'b0;

  always #10 clk = ~clk;

  mxbus_ctrl #(.AW(16), .DW(8), .PH_CYC(PH)) i_mxbus_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_exp(mode_exp),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .port_hi_wr(port_hi_wr), .port_hi_data(port_hi_data),
    .port_lo_wr(port_lo_wr), .port_lo_data(port_lo_data),
    .port_lo_dir(port_lo_dir), .port_lo_in(port_lo_in),
    .stra_clr(stra_clr), .stra_flag(stra_flag),
    .pin_hi_out(pin_hi_out), .pin_ad_o(pin_ad_o), .pin_ad_oe(pin_ad_oe),
    .pin_ad_i(pin_ad_i), .pin_as_o(pin_as_o), .pin_as_oe(pin_as_oe),
    .pin_as_i(pin_as_i), .pin_rw_o(pin_rw_o), .pin_e(pin_e)
  );

  // External transparent address latch and memory
  always_latch if (pin_as_o) lat_lo = pin_ad_o;

  assign pin_ad_i = !mode_exp ? ext_port :
                    (pin_e && pin_rw_o) ? mem[lat_lo] :
                    ((|pin_ad_oe) ? pin_ad_o : 8'hEE);

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mode_exp && pin_e && !pin_rw_o) mem[lat_lo] <= pin_ad_o;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bus monitor during the vector walk
  always @(negedge clk) begin
    if (run_mon) begin
      if (rsp_done) begin
        if (!VECS[k].wr) check("R4 read data", 16'(rsp_rdata), 16'(VECS[k].exp));
        if (k > 0) check("R7 spacing", 16'(cyc - last_done), 16'(4 * PH));
        last_done = cyc;
        k = k + 1;
      end
      if (pin_e && k < NV) begin
        check("R2 latched address", {pin_hi_out, lat_lo}, VECS[k].addr);
        check("R6 rw level", 16'(pin_rw_o), 16'(!VECS[k].wr));
        if (VECS[k].wr) begin
          check("R5 write drive oe", 16'(pin_ad_oe), 16'hFF);
          check("R5 write data", 16'(pin_ad_o), 16'(VECS[k].wd));
        end else begin
          check("R4 read release", 16'(pin_ad_oe), 16'h00);
        end
      end
      if (prev_as && !pin_as_o && k < NV) begin
        check("R3 addr after strobe", 16'(pin_ad_o), 16'(VECS[k].addr[7:0]));
        check("R3 addr oe after strobe", 16'(pin_ad_oe), 16'hFF);
      end
      if (prev_e && !pin_e) check("R5 release at E fall", 16'(pin_ad_oe), 16'h00);
      check("R3 as/e exclusive", 16'(pin_as_o && pin_e), 16'h0);
    end
    prev_as = pin_as_o;
    prev_e  = pin_e;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check("R1 ready after reset", 16'(req_ready), 16'h1);
    check("R3 strobe idle", 16'(pin_as_o), 16'h0);
    check("R6 rw idle high", 16'(pin_rw_o), 16'h1);
    check("R4 bus released idle", 16'(pin_ad_oe), 16'h00);
    check("R7 no done", 16'(rsp_done), 16'h0);
    check("R10 flag clear", 16'(stra_flag), 16'h0);

    // R1: no request, nothing starts
    repeat (4) @(negedge clk);
    check("R1 idle no strobe", 16'(pin_as_o), 16'h0);
    check("R1 idle ready", 16'(req_ready), 16'h1);

    // Vector walk, back to back
    run_mon = 1'b1;
    for (int i = 0; i < NV; i++) begin
      req_valid = 1'b1;
      req_addr  = VECS[i].addr;
      req_wdata = VECS[i].wd;
      req_write = VECS[i].wr;
      #1;
      while (!req_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    repeat (6 * PH) @(negedge clk);
    run_mon = 1'b0;
    check("R7 all cycles done", 16'(k), 16'(NV));

    // R11: port activity in expanded mode is ignored
    port_hi_wr = 1'b1; port_hi_data = 8'h11;
    port_lo_wr = 1'b1; port_lo_data = 8'h22;
    @(negedge clk);
    port_hi_wr = 1'b0; port_lo_wr = 1'b0;
    check("R11 no strobe in expanded", 16'(pin_rw_o), 16'h1);
    pin_as_i = 1'b1;
    repeat (4) @(negedge clk);
    pin_as_i = 1'b0;
    repeat (4) @(negedge clk);
    mode_exp = 1'b0;
    port_lo_dir = 8'hFF;
    #1;
    check("R11 flag untouched", 16'(stra_flag), 16'h0);
    check("R11 hi port untouched", 16'(pin_hi_out), 16'h00);
    check("R11 lo port untouched", 16'(pin_ad_o), 16'h00);

    // R8: single-chip pin roles
    check("R8 ready low", 16'(req_ready), 16'h0);
    check("R8 strobe pin input", 16'(pin_as_oe), 16'h0);
    check("R8 E low", 16'(pin_e), 16'h0);
    @(negedge clk);

    // R9: output port write and strobe
    port_hi_wr = 1'b1; port_hi_data = 8'hA7;
    @(negedge clk);
    port_hi_wr = 1'b0;
    check("R9 strobe high", 16'(pin_rw_o), 16'h1);
    check("R8 hi port value", 16'(pin_hi_out), 16'hA7);
    @(negedge clk);
    check("R9 strobe one clock", 16'(pin_rw_o), 16'h0);

    // R8: shared-byte port
    port_lo_dir = 8'hF0;
    port_lo_wr = 1'b1; port_lo_data = 8'h5C;
    @(negedge clk);
    port_lo_wr = 1'b0;
    check("R8 lo port oe", 16'(pin_ad_oe), 16'hF0);
    check("R8 lo port value", 16'(pin_ad_o), 16'h5C);
    ext_port = 8'h3B;
    @(negedge clk);
    check("R8 lo port input", 16'(port_lo_in), 16'h3B);

    // R10: input strobe flag
    pin_as_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 flag not yet", 16'(stra_flag), 16'h0);
    @(negedge clk);
    check("R10 flag set", 16'(stra_flag), 16'h1);
    repeat (3) @(negedge clk);
    check("R10 flag sticky", 16'(stra_flag), 16'h1);
    stra_clr = 1'b1;
    @(negedge clk);
    stra_clr = 1'b0;
    check("R10 flag cleared", 16'(stra_flag), 16'h0);
    repeat (4) @(negedge clk);
    check("R10 level does not reset flag", 16'(stra_flag), 16'h0);
    pin_as_i = 1'b0;
    repeat (3) @(negedge clk);
    pin_as_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 new edge sets flag", 16'(stra_flag), 16'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule